// File: doc/BRIEF.md
# Generic Clock Generator Controller

This block produces a set of derived clocks from a small pool of clock sources. It holds several clock generators, each of which picks one of eight sources, optionally divides it by an integer, and can be switched on or off on its own. The output of generator 1 can itself be a source for the other generators. Generator 0 always feeds the main system clock output. Each generator also has one dedicated pad: the pad level is always offered to that generator as a source, and the generator can drive its own clock onto the pad instead.

A bank of peripheral clock channels routes generator outputs to consumers. A channel is configured by one 16-bit write that carries the channel number, the generator number, an enable and a lock. Generators and channels can be write-locked. A lock holds until the next hardware reset. A software reset returns every unlocked generator and channel to its default, and leaves locked entries untouched.

All source and pad inputs are levels sampled on `clk`. Every generated clock is a registered level on `clk`, so the design has a single clock domain.

Top module: `gclk_ctrl`

## Requirements
- R1: After hardware reset, generator 0 is enabled on source 0 with no division. All other generators are disabled. Source, divider, pad-drive and lock fields are cleared. All channels are disabled and select generator 0. `chan_clk` and `pad_oe` are all zero.
- R2: A write with `wr_addr`=1 configures a generator. The fields are: id in bits [3:0], source in [6:4], enable in [7], pad drive in [8], lock in [9]. Source codes 0 to 5 pick `src_in[code]`, code 6 picks the generator's own `pad_in` bit, and code 7 picks generator 1's output. With a divide value of 0 or 1, an enabled generator outputs its selected source one `clk` cycle later.
- R3: A generator-configuration write that addresses generator 1 with source code 7 is ignored as a whole. Generator 1 keeps its previous source and settings.
- R4: A write with `wr_addr`=2 sets a generator's divide value N: id in [3:0], N in [15:8]. For N of 2 or more, the output starts low after enable and inverts on every Nth change of the selected source level.
- R5: While a generator's enable bit is 0, its output is low and its divider count is cleared. Clearing the bit forces the output low in the cycle after the write.
- R6: `pad_oe[g]` equals generator g's pad-drive bit. `pad_out[g]` carries generator g's output when that bit is set, and is 0 otherwise.
- R7: `main_clk` is generator 0's output.
- R8: A write with `wr_addr`=3 configures one channel in a single 16-bit word: channel id in [5:0], generator select in [11:8], enable in [14], lock in [15]. An enabled channel outputs the selected generator's clock. A disabled channel outputs 0.
- R9: A write with `wr_addr`=0 and bit 0 set is a software reset. It returns every unlocked generator and channel to its R1 state in the next cycle, including the generator output and divider count.
- R10: A generator or channel whose lock bit is set ignores all later configuration writes and keeps its configuration and running state through software reset. Only a hardware reset clears the lock.
- R11: A write is ignored if it names a generator id at or beyond the generator count, a channel id at or beyond the channel count, or a channel generator select at or beyond the generator count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling and outputs are on its rising edge |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register select: 0 control, 1 generator config, 2 generator divide, 3 channel config |
| wr_data | input | 16 | Write data |
| src_in | input | 6 | Clock source levels, codes 0 to 5 |
| pad_in | input | NGEN | Per-generator pad input level, source code 6 |
| pad_out | output | NGEN | Per-generator pad output level |
| pad_oe | output | NGEN | Per-generator pad output enable |
| main_clk | output | 1 | Main system clock from generator 0 |
| chan_clk | output | NCH | Per-channel routed peripheral clock |

## Verification
The assertions assume that at most one register write arrives per cycle. They also assume that configuration state changes only through `wr_en` cycles or a hardware reset, so a locked entry that moves without a reset is a real fault. The bench keeps to this by issuing writes one at a time from a single task and by holding `rst_n` low across whole cycles. The source and pad inputs toggle at several unrelated fixed rates. Because of this, source swaps and divider settings land at arbitrary points in the source waveform, and every cycle is compared against the reference model.

// File: rtl/gclk_pkg.sv
// Shared types, register map and field positions for the clock controller.
// Assumes at most 16 generators and at most 64 channels (id field widths).
package gclk_pkg;

    localparam int SRC_W  = 3;
    localparam int DIV_W  = 8;
    localparam int NEXT   = (1 << SRC_W) - 2;   // external source codes
    localparam logic [SRC_W-1:0] SRC_PAD = SRC_W'(NEXT);
    localparam logic [SRC_W-1:0] SRC_G1  = SRC_W'(NEXT + 1);

    // register addresses
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_GCFG = 2'd1;
    localparam logic [1:0] A_GDIV = 2'd2;
    localparam logic [1:0] A_CCFG = 2'd3;

    // generator config fields
    localparam int GF_ID   = 0;
    localparam int GF_SRC  = 4;
    localparam int GF_EN   = 7;
    localparam int GF_PIN  = 8;
    localparam int GF_LOCK = 9;
    localparam int GD_VAL  = 8;

    // channel config fields
    localparam int CF_ID   = 0;
    localparam int CF_GEN  = 8;
    localparam int CF_EN   = 14;
    localparam int CF_LOCK = 15;

    typedef struct packed {
        logic             lock;
        logic             pin;
        logic             en;
        logic [DIV_W-1:0] div;
        logic [SRC_W-1:0] src;
    } gen_cfg_t;

    typedef struct packed {
        logic       lock;
        logic       en;
        logic [3:0] gen;
    } chan_cfg_t;

    // default generator state; only the main generator runs out of reset
    function automatic gen_cfg_t gen_default(input logic is_main);
        gen_cfg_t d;
        d      = '0;
        d.en   = is_main;
        return d;
    endfunction

endpackage

// File: rtl/gclk_regs.sv
// Register decode and configuration storage for generators and channels.
// Handles write-lock, software reset and the generator-1 self-select rule.
// Assumes one write per cycle and synchronous active-low reset.
module gclk_regs
    import gclk_pkg::*;
#(
    parameter int NGEN = 4,
    parameter int NCH  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [15:0]           wr_data,
    output gen_cfg_t [NGEN-1:0]   gcfg,
    output chan_cfg_t [NCH-1:0]   ccfg,
    output logic                  srst
);

    logic       wr_gcfg;
    logic       wr_gdiv;
    logic       wr_ccfg;
    logic [3:0] gsel_w;
    logic       gsel_ok;
    logic       unused_bits;

    // decode the register strobes for this cycle
    always_comb begin
        srst    = wr_en && (wr_addr == A_CTRL) && wr_data[0];
        wr_gcfg = wr_en && (wr_addr == A_GCFG);
        wr_gdiv = wr_en && (wr_addr == A_GDIV);
        wr_ccfg = wr_en && (wr_addr == A_CCFG);
        gsel_w  = wr_data[CF_GEN +: 4];
        gsel_ok = 32'(gsel_w) < NGEN;
    end

    assign unused_bits = ^wr_data[13:12];

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        gen_cfg_t cfg_q;
        logic     hit;
        logic     self_bad;

        assign hit      = (wr_data[GF_ID +: 4] == 4'(g)) && !cfg_q.lock;
        assign self_bad = (g == 1) && (wr_data[GF_SRC +: SRC_W] == SRC_G1);

        // hold one generator's configuration
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= gen_default(g == 0);
            end else if (srst && !cfg_q.lock) begin
                cfg_q <= gen_default(g == 0);
            end else if (wr_gcfg && hit && !self_bad) begin
                cfg_q.src  <= wr_data[GF_SRC +: SRC_W];
                cfg_q.en   <= wr_data[GF_EN];
                cfg_q.pin  <= wr_data[GF_PIN];
                cfg_q.lock <= wr_data[GF_LOCK];
            end else if (wr_gdiv && hit) begin
                cfg_q.div  <= wr_data[GD_VAL +: DIV_W];
            end
        end

        assign gcfg[g] = cfg_q;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_cfg_t cfg_q;

        // hold one channel's routing entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (srst && !cfg_q.lock) begin
                cfg_q <= '0;
            end else if (wr_ccfg && gsel_ok && !cfg_q.lock &&
                         (wr_data[CF_ID +: 6] == 6'(c))) begin
                cfg_q.gen  <= gsel_w;
                cfg_q.en   <= wr_data[CF_EN];
                cfg_q.lock <= wr_data[CF_LOCK];
            end
        end

        assign ccfg[c] = cfg_q;
    end

endmodule

// File: rtl/gclk_gen.sv
// One clock generator: source mux, integer divider on source level changes,
// and output gating by the enable bit. NO_SELF marks generator 1, whose
// own-output source code is never accepted by the registers.
module gclk_gen
    import gclk_pkg::*;
#(
    parameter bit NO_SELF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [SRC_W-1:0] src,
    input  logic [DIV_W-1:0] div,
    input  logic [NEXT-1:0]  ext_src,
    input  logic             pad_in,
    input  logic             g1_clk,
    output logic             gen_clk
);

    logic             sel;
    logic             src_q;
    logic             out_q;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W:0]   cnt_nxt;
    logic             wrap;

    // pick the selected source level
    always_comb begin
        if (src == SRC_G1)
            sel = NO_SELF ? 1'b0 : g1_clk;
        else if (src == SRC_PAD)
            sel = pad_in;
        else
            sel = ext_src[src];
    end

    assign cnt_nxt = {1'b0, cnt} + (DIV_W+1)'(1);
    assign wrap    = cnt_nxt >= {1'b0, div};

    // follow or divide the source, cleared while disabled or reset by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            out_q <= 1'b0;
            cnt   <= '0;
        end else begin
            src_q <= sel;
            if (clr || !en) begin
                out_q <= 1'b0;
                cnt   <= '0;
            end else if (div <= DIV_W'(1)) begin
                out_q <= sel;
            end else if (sel != src_q) begin
                if (wrap) begin
                    cnt   <= '0;
                    out_q <= ~out_q;
                end else begin
                    cnt   <= cnt_nxt[DIV_W-1:0];
                end
            end
        end
    end

    assign gen_clk = out_q & en;

endmodule

// File: rtl/gclk_route.sv
// Peripheral channel routing: each enabled channel forwards one generator
// clock. Assumes the stored generator select is always in range.
module gclk_route
    import gclk_pkg::*;
#(
    parameter int NGEN = 4,
    parameter int NCH  = 6
) (
    input  logic [NGEN-1:0]      gen_clk,
    input  chan_cfg_t [NCH-1:0]  ccfg,
    output logic [NCH-1:0]       chan_clk
);

    localparam int GW = $clog2(NGEN);

    logic unused_cfg;

    // forward the selected generator clock for each enabled channel
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            chan_clk[c] = ccfg[c].en && gen_clk[ccfg[c].gen[GW-1:0]];
        end
    end

    always_comb begin
        unused_cfg = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            unused_cfg = unused_cfg ^ ccfg[c].lock ^ (^ccfg[c].gen);
        end
    end

endmodule

// File: rtl/gclk_ctrl.sv
// Top of the clock controller: registers, one generator per index, pad
// drive and channel routing. Generator 1 output is a shared source.
// Needs NGEN between 2 and 16 and NCH between 1 and 64.
module gclk_ctrl
    import gclk_pkg::*;
#(
    parameter int NGEN = 4,
    parameter int NCH  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [5:0]        src_in,
    input  logic [NGEN-1:0]   pad_in,
    output logic [NGEN-1:0]   pad_out,
    output logic [NGEN-1:0]   pad_oe,
    output logic              main_clk,
    output logic [NCH-1:0]    chan_clk
);

    gen_cfg_t [NGEN-1:0] gcfg;
    chan_cfg_t [NCH-1:0] ccfg;
    logic                srst;
    logic [NGEN-1:0]     gen_clk;

    gclk_regs #(.NGEN(NGEN), .NCH(NCH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .gcfg    (gcfg),
        .ccfg    (ccfg),
        .srst    (srst)
    );

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        gclk_gen #(.NO_SELF(g == 1)) u_gen (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (srst && !gcfg[g].lock),
            .en      (gcfg[g].en),
            .src     (gcfg[g].src),
            .div     (gcfg[g].div),
            .ext_src (src_in[NEXT-1:0]),
            .pad_in  (pad_in[g]),
            .g1_clk  ((g == 1) ? 1'b0 : gen_clk[1]),
            .gen_clk (gen_clk[g])
        );

        // pad drive follows the generator's pad-drive bit
        always_comb begin
            pad_oe[g]  = gcfg[g].pin;
            pad_out[g] = gcfg[g].pin && gen_clk[g];
        end
    end

    assign main_clk = gen_clk[0];

    gclk_route #(.NGEN(NGEN), .NCH(NCH)) u_route (
        .gen_clk  (gen_clk),
        .ccfg     (ccfg),
        .chan_clk (chan_clk)
    );

endmodule

// File: rtl/gclk_ctrl_chk.sv
// Property checker for gclk_ctrl, attached by bind. Assumes one write per
// cycle and that configuration moves only on writes or hardware reset.
module gclk_ctrl_chk
    import gclk_pkg::*;
#(
    parameter int NGEN = 4,
    parameter int NCH  = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [15:0]         wr_data,
    input gen_cfg_t [NGEN-1:0] gcfg,
    input chan_cfg_t [NCH-1:0] ccfg,
    input logic                main_clk,
    input logic [NCH-1:0]      chan_clk,
    input logic [NGEN-1:0]     pad_oe
);

    logic unused_hi;
    assign unused_hi = ^wr_data[15:8];

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chan_clk == '0 && pad_oe == '0));

    // R3
    no_self_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_GCFG && wr_data[3:0] == 4'd1 &&
         wr_data[6:4] == SRC_G1) |=> $stable(gcfg[1]));

    // R5
    main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_GCFG && wr_data[3:0] == 4'd0 &&
         !wr_data[GF_EN] && !gcfg[0].lock) |=> !main_clk);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R9
        soft_rst_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_CTRL && wr_data[0] && !ccfg[c].lock)
            |=> !chan_clk[c]);

        // R10
        chan_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ccfg[c].lock |=> $stable(ccfg[c]));
    end

    for (genvar g = 0; g < NGEN; g++) begin : g_g
        // R10
        gen_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gcfg[g].lock |=> $stable(gcfg[g]));
    end

endmodule

bind gclk_ctrl gclk_ctrl_chk #(.NGEN(NGEN), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .gcfg     (gcfg),
    .ccfg     (ccfg),
    .main_clk (main_clk),
    .chan_clk (chan_clk),
    .pad_oe   (pad_oe)
);

// File: tb/gclk_ctrl_test.sv
`timescale 1ns/1ps
module gclk_ctrl_test;

    localparam int NGEN = 4;
    localparam int NCH  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_addr = '0;
    logic [15:0]     wr_data = '0;
    logic [5:0]      src_in = '0;
    logic [NGEN-1:0] pad_in = '0;
    logic [NGEN-1:0] pad_out;
    logic [NGEN-1:0] pad_oe;
    logic            main_clk;
    logic [NCH-1:0]  chan_clk;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string phase = "R1 reset";

    gclk_ctrl #(.NGEN(NGEN), .NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_in(src_in), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .main_clk(main_clk),
        .chan_clk(chan_clk)
    );

    always #2 clk = ~clk;

    // ---------------- reference model ----------------
    int m_src [NGEN];
    int m_div [NGEN];
    bit m_en  [NGEN];
    bit m_pin [NGEN];
    bit m_lk  [NGEN];
    bit m_out [NGEN];
    bit m_prv [NGEN];
    int m_cnt [NGEN];
    bit m_cen [NCH];
    int m_cg  [NCH];
    bit m_clk [NCH];
    bit sv    [NGEN];

    task automatic gen_reset(input int g);
        m_src[g] = 0; m_div[g] = 0; m_en[g] = (g == 0);
        m_pin[g] = 0; m_lk[g] = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NGEN; g++) begin
                gen_reset(g); m_out[g] = 0; m_prv[g] = 0; m_cnt[g] = 0;
            end
            for (int c = 0; c < NCH; c++) begin
                m_cen[c] = 0; m_cg[c] = 0; m_clk[c] = 0;
            end
        end else begin
            bit g1;
            bit sr;
            int id;
            int gs;
            g1 = m_out[1] & m_en[1];
            for (int g = 0; g < NGEN; g++) begin
                if (m_src[g] == 7)      sv[g] = g1;
                else if (m_src[g] == 6) sv[g] = pad_in[g];
                else                    sv[g] = src_in[m_src[g]];
            end
            sr = wr_en && wr_addr == 0 && wr_data[0];
            for (int g = 0; g < NGEN; g++) begin
                if ((sr && !m_lk[g]) || !m_en[g]) begin
                    m_out[g] = 0; m_cnt[g] = 0;
                end else if (m_div[g] <= 1) begin
                    m_out[g] = sv[g];
                end else if (sv[g] != m_prv[g]) begin
                    if (m_cnt[g] + 1 >= m_div[g]) begin
                        m_cnt[g] = 0; m_out[g] = !m_out[g];
                    end else m_cnt[g]++;
                end
                m_prv[g] = sv[g];
            end
            if (sr) begin
                for (int g = 0; g < NGEN; g++) if (!m_lk[g]) gen_reset(g);
                for (int c = 0; c < NCH; c++) if (!m_clk[c]) begin
                    m_cen[c] = 0; m_cg[c] = 0;
                end
            end else if (wr_en) begin
                id = int'(wr_data[3:0]);
                if (wr_addr == 1 && id < NGEN && !m_lk[id] &&
                    !(id == 1 && wr_data[6:4] == 7)) begin
                    m_src[id] = int'(wr_data[6:4]); m_en[id] = wr_data[7];
                    m_pin[id] = wr_data[8]; m_lk[id] = wr_data[9];
                end
                if (wr_addr == 2 && id < NGEN && !m_lk[id])
                    m_div[id] = int'(wr_data[15:8]);
                id = int'(wr_data[5:0]);
                gs = int'(wr_data[11:8]);
                if (wr_addr == 3 && id < NCH && gs < NGEN && !m_clk[id]) begin
                    m_cg[id] = gs; m_cen[id] = wr_data[14]; m_clk[id] = wr_data[15];
                end
            end
        end
    end

    function automatic bit mg(input int g);
        return m_out[g] & m_en[g];
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            logic [NCH-1:0]  ec;
            logic [NGEN-1:0] eo;
            logic [NGEN-1:0] ep;
            for (int c = 0; c < NCH; c++) ec[c] = m_cen[c] && mg(m_cg[c]);
            for (int g = 0; g < NGEN; g++) begin
                eo[g] = m_pin[g];
                ep[g] = m_pin[g] && mg(g);
            end
            chk({phase, " / R7 main_clk"}, 32'(main_clk), 32'(mg(0)));
            chk({phase, " / R8 chan_clk"}, 32'(chan_clk), 32'(ec));
            chk({phase, " / R6 pad_oe"}, 32'(pad_oe), 32'(eo));
            chk({phase, " / R6 pad_out"}, 32'(pad_out), 32'(ep));
        end
        for (int k = 0; k < 6; k++) if (cyc % (k + 1) == 0) src_in[k] = ~src_in[k];
        for (int g = 0; g < NGEN; g++) if (cyc % (g + 3) == 1) pad_in[g] = ~pad_in[g];
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] gw(input int id, input int src, input bit en,
                                       input bit pin, input bit lk);
        return 16'(id) | 16'(src << 4) | 16'(en) << 7 | 16'(pin) << 8 | 16'(lk) << 9;
    endfunction

    function automatic logic [15:0] cw(input int id, input int gsel, input bit en,
                                       input bit lk);
        return 16'(id) | 16'(gsel << 8) | 16'(en) << 14 | 16'(lk) << 15;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 chan_clk after reset", 32'(chan_clk), 32'd0);
        chk("R1 pad_oe after reset", 32'(pad_oe), 32'd0);

        phase = "R2 source select";
        wr(1, gw(0, 3, 1, 0, 0));
        wr(1, gw(2, 6, 1, 1, 0));
        wr(3, cw(0, 2, 1, 0));
        idle(20);

        phase = "R3 gen1 self select";
        wr(1, gw(1, 2, 1, 0, 0));
        wr(3, cw(1, 1, 1, 0));
        wr(1, gw(3, 7, 1, 0, 0));
        wr(3, cw(2, 3, 1, 0));
        idle(10);
        wr(1, gw(1, 7, 1, 0, 0));
        idle(20);

        phase = "R4 divider";
        wr(2, 16'h0402);
        wr(2, 16'h0300);
        wr(2, 16'h0103);
        idle(60);
        wr(2, 16'h0202);
        wr(2, 16'h0501);
        idle(40);

        phase = "R5 gating";
        wr(1, gw(2, 6, 0, 1, 0));
        chk("R5 pad_out low after disable", 32'(pad_out[2]), 32'd0);
        idle(10);
        wr(1, gw(2, 6, 1, 1, 0));
        idle(30);

        phase = "R6 pad drive";
        wr(1, gw(1, 2, 1, 1, 0));
        wr(1, gw(0, 3, 1, 1, 0));
        chk("R6 pad_oe pattern", 32'(pad_oe), 32'h7);
        idle(20);

        phase = "R8 R11 channels";
        wr(3, cw(3, 0, 1, 0));
        wr(3, cw(4, 9, 1, 0));
        wr(3, cw(40, 1, 1, 0));
        wr(3, cw(5, 1, 0, 0));
        wr(1, gw(7, 0, 1, 1, 0));
        chk("R11 chan 4 ignored", 32'(chan_clk[4]), 32'd0);
        idle(20);

        phase = "R10 lock";
        wr(1, gw(2, 6, 1, 1, 1));
        wr(3, cw(0, 2, 1, 1));
        wr(1, gw(2, 0, 0, 0, 0));
        wr(2, 16'h0602);
        wr(3, cw(0, 0, 0, 0));
        chk("R10 locked pad_oe kept", 32'(pad_oe[2]), 32'd1);
        idle(20);

        phase = "R9 soft reset";
        wr(0, 16'h0001);
        chk("R9 pad_oe after soft reset", 32'(pad_oe), 32'h4);
        chk("R9 chan 1 cleared", 32'(chan_clk[1]), 32'd0);
        idle(40);

        phase = "R10 hardware reset";
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 lock cleared by hw reset", 32'(pad_oe), 32'd0);
        wr(1, gw(1, 4, 1, 0, 0));
        wr(3, cw(0, 1, 1, 0));
        idle(20);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule